// File: doc/BRIEF.md
# Serial Converter Output Sequencer

This block is the digital side of a 16-bit serial sampling converter. It is meant to stand in for the converter in system-level tests. A host lowers an active-low select and toggles a serial clock. The block spends the opening clock periods in a sampling window. It then drives a single zero bit, sends the sample word most significant bit first, and, if select stays low, sends the word again least significant bit first. After that it releases the data line. Raising select at any moment abandons the cycle.

The sample word comes from a 16-bit parallel input, in straight binary. The word is captured on the falling serial clock edge that closes the sampling window. The block reports a busy flag and two power-down flags. The analog flag is set once the conversion is complete. The full flag is set only while select is high.

All inputs are sampled on a system clock `clk` and are assumed synchronous to it. A serial clock edge or select edge counts when a change is seen between two consecutive `clk` samples. The registered outputs then move on the `clk` rising edge at which the change is first seen.

Top module: `serial_conv_seq`

## Requirements
- R1: After reset, with select high, the data line is released (`sdoEn`=0), `busy`=0, `analogPd`=1 and `fullPd`=1.
- R2: A high-to-low change of `csN` starts a cycle: `busy`=1 and both power-down flags are 0. The data line stays released through the first four falling `sclk` edges.
- R3: On the 5th falling `sclk` edge of a cycle, the data line is enabled and drives 0 for one serial clock period.
- R4: On falling edges 6 to 21, the line carries word bits 15 down to 0, in that order (most significant bit first).
- R5: On falling edges 22 to 36, the line carries word bits 1 up to 15, in that order. Bit 0 is not sent a second time.
- R6: On falling edge 37 the line is released. Later falling edges change no output while `csN` stays low.
- R7: On falling edge 22, `busy` goes to 0 and `analogPd` goes to 1, while `fullPd` stays 0. `fullPd` is 1 only while `csN` is high, and `busy` and `fullPd` are never 1 together.
- R8: A new cycle starts only when `csN` has gone high and then low again. Serial clock edges while `csN` is high have no effect.
- R9: `csN` high during a cycle ends it on the next `clk` edge: the line is released, `busy`=0, `analogPd`=1 and `fullPd`=1.
- R10: `sampleWord` is captured on the 5th falling edge. Changes to it before that edge are reflected in the output, and changes after it are not.
- R11: The word is sent unmodified in straight binary: 0000h, 8000h, FFFFh and other patterns appear bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select; low starts a cycle, high aborts or idles |
| sclk | input | 1 | Serial clock; falling edges advance the sequence |
| sampleWord | input | 16 | Parallel conversion result, straight binary |
| sdo | output | 1 | Serial data value |
| sdoEn | output | 1 | Data line drive enable (0 = high impedance) |
| busy | output | 1 | Conversion in progress |
| analogPd | output | 1 | Analog section powered down |
| fullPd | output | 1 | Whole block powered down |

## Verification
The bench targets the seam between the two passes. A design that repeats bit 0, or skips bit 1, shifts every reversed bit by one edge and misreports edges 22 to 36. It checks that the line is released on exactly edge 37 and stays released while the clock keeps running. A design that wraps around would start a third pass. Aborts are placed both in the sampling window and mid-word, to catch a design that keeps driving or leaves busy set. The sample input is changed on both sides of the capture edge, so a design that captures early or keeps tracking the input would send the wrong word.

// File: rtl/serial_conv_seq_pkg.sv
package serial_conv_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SAMPLE = 3'd1,
    PH_FWD    = 3'd2,
    PH_REV    = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic capture;  // latch word, drive the null bit
    logic stepFwd;  // next bit, descending
    logic stepRev;  // next bit, ascending
    logic park;     // release the line
  } strobe_t;

endpackage

// File: rtl/serial_conv_seq_ctrl.sv
module serial_conv_seq_ctrl
  import serial_conv_seq_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter int SAMPLE_EDGES = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  output strobe_t strb,
  output logic    busyO,
  output logic    analogPdO,
  output logic    fullPdO
);

  localparam int CNT_W = $clog2(WIDTH + SAMPLE_EDGES + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_EDGES - 1);
  localparam logic [CNT_W-1:0] FWD_LAST    = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] REV_END     = CNT_W'(WIDTH - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] edgeCnt, edgeCntNext;
  logic             sclkQ, csQ;
  logic             sclkFall, csFall;

  assign sclkFall = sclkQ & ~sclk;
  assign csFall   = csQ & ~csN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
    end
  end

  always_comb begin
    phaseNext   = phase;
    edgeCntNext = edgeCnt;
    strb        = '0;
    if (phase != PH_IDLE && csN) begin
      // abort or end of cycle: select high wins over everything
      phaseNext   = PH_IDLE;
      edgeCntNext = '0;
      strb.park   = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (csFall) begin
            phaseNext   = PH_SAMPLE;
            edgeCntNext = '0;
          end
        end
        PH_SAMPLE: begin
          if (sclkFall) begin
            if (edgeCnt == SAMPLE_LAST) begin
              strb.capture = 1'b1;
              phaseNext    = PH_FWD;
              edgeCntNext  = '0;
            end else begin
              edgeCntNext = edgeCnt + 1'b1;
            end
          end
        end
        PH_FWD: begin
          if (sclkFall) begin
            strb.stepFwd = 1'b1;
            if (edgeCnt == FWD_LAST) begin
              phaseNext   = PH_REV;
              edgeCntNext = '0;
            end else begin
              edgeCntNext = edgeCnt + 1'b1;
            end
          end
        end
        PH_REV: begin
          if (sclkFall) begin
            if (edgeCnt == REV_END) begin
              strb.park = 1'b1;
              phaseNext = PH_DONE;
            end else begin
              strb.stepRev = 1'b1;
              edgeCntNext  = edgeCnt + 1'b1;
            end
          end
        end
        PH_DONE: begin
          phaseNext = PH_DONE;
        end
        default: begin
          phaseNext   = PH_IDLE;
          edgeCntNext = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      edgeCnt <= '0;
    end else begin
      phase   <= phaseNext;
      edgeCnt <= edgeCntNext;
    end
  end

  // busy spans sampling and the forward pass (REV with count 0 is the bit-0 period)
  assign busyO     = (phase == PH_SAMPLE) || (phase == PH_FWD) ||
                     ((phase == PH_REV) && (edgeCnt == '0));
  assign analogPdO = (phase == PH_IDLE) || (phase == PH_DONE) ||
                     ((phase == PH_REV) && (edgeCnt != '0));
  assign fullPdO   = (phase == PH_IDLE);

  // R9: select high inside a cycle always returns to idle
  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && csN) |=> (phase == PH_IDLE));

  // R8: a finished cycle holds while select stays low
  a_r8_hold_done: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && !csN) |=> (phase == PH_DONE));

  // R7: busy and full power-down exclusive
  a_r7_busy_not_full_pd: assert property (@(posedge clk) disable iff (!rstN)
    !(busyO && fullPdO));

  // R4: at most one datapath strobe per cycle
  a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/serial_conv_seq_dp.sv
module serial_conv_seq_dp
  import serial_conv_seq_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] sampleWord,
  output logic             sdoO,
  output logic             sdoEnO
);

  localparam int PTR_W = $clog2(WIDTH);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(WIDTH - 1);

  logic [WIDTH-1:0] wordQ;
  logic [PTR_W-1:0] bitPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ  <= '0;
      bitPtr <= '0;
      sdoO   <= 1'b0;
      sdoEnO <= 1'b0;
    end else if (strb.park) begin
      sdoO   <= 1'b0;
      sdoEnO <= 1'b0;
    end else if (strb.capture) begin
      wordQ  <= sampleWord;
      bitPtr <= PTR_TOP;
      sdoO   <= 1'b0;
      sdoEnO <= 1'b1;
    end else if (strb.stepFwd) begin
      sdoO <= wordQ[bitPtr];
      // after bit 0 the reversed pass resumes at bit 1
      bitPtr <= (bitPtr == '0) ? PTR_W'(1) : bitPtr - 1'b1;
    end else if (strb.stepRev) begin
      sdoO   <= wordQ[bitPtr];
      bitPtr <= bitPtr + 1'b1;
    end
  end

  // R3: capture is followed by the enabled null bit
  a_r3_null_bit: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (sdoEnO && !sdoO));

  // R6: parking always releases the line
  a_r6_park_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.park |=> !sdoEnO);

  // R10: the held word only changes on capture
  a_r10_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(wordQ));

endmodule

// File: rtl/serial_conv_seq.sv
module serial_conv_seq
  import serial_conv_seq_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter int SAMPLE_EDGES = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic [WIDTH-1:0] sampleWord,
  output logic             sdo,
  output logic             sdoEn,
  output logic             busy,
  output logic             analogPd,
  output logic             fullPd
);

  strobe_t strb;

  serial_conv_seq_ctrl #(
    .WIDTH(WIDTH),
    .SAMPLE_EDGES(SAMPLE_EDGES)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .csN(csN),
    .sclk(sclk),
    .strb(strb),
    .busyO(busy),
    .analogPdO(analogPd),
    .fullPdO(fullPd)
  );

  serial_conv_seq_dp #(
    .WIDTH(WIDTH)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .sampleWord(sampleWord),
    .sdoO(sdo),
    .sdoEnO(sdoEn)
  );

  // R7: the line is never driven in full power-down
  a_r7_no_drive_in_full_pd: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !fullPd);

endmodule

// File: tb/serial_conv_seq_tb_top.sv
module serial_conv_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic [15:0] sampleWord = '0;
  logic        sdo, sdoEn, busy, analogPd, fullPd;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_conv_seq dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleWord(sampleWord),
    .sdo(sdo), .sdoEn(sdoEn), .busy(busy), .analogPd(analogPd), .fullPd(fullPd)
  );

  // {enable, driven value, busy, analogPd, fullPd}
  task automatic check5(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {sdoEn, sdoEn & sdo, busy, analogPd, fullPd};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (en,sdo,busy,aPd,fPd)", tag, act, exp);
    end
  endtask

  // one serial period ending with a falling edge, sampled after the update
  task automatic pulse();
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic raiseCs();
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic lowerCs();
    csN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // full cycle for word w, input changed before and after capture (R10)
  task automatic runWord(logic [15:0] w);
    string tag;
    logic [4:0] exp;
    raiseCs();
    sampleWord = ~w;
    lowerCs();
    check5("R2 start", 5'b00100);
    for (int k = 1; k <= 40; k++) begin
      pulse();
      if (k < 5)       begin exp = 5'b00100;                      tag = "R2 sampling"; end
      else if (k == 5) begin exp = 5'b10100;                      tag = "R3 null bit"; end
      else if (k <= 21) begin exp = {1'b1, w[21-k], 3'b100};      tag = "R4 R10 R11 forward"; end
      else if (k <= 36) begin exp = {1'b1, w[k-21], 3'b010};      tag = "R5 R7 reverse"; end
      else             begin exp = 5'b00010;                      tag = "R6 R8 released"; end
      check5($sformatf("%s edge %0d word %h", tag, k, w), exp);
      if (k == 4) sampleWord = w;
      if (k == 5) sampleWord = ~w;
    end
    raiseCs();
    check5("R7 full pd with cs high", 5'b00011);
  endtask

  task automatic abortAt(int n, logic [15:0] w);
    raiseCs();
    sampleWord = w;
    lowerCs();
    for (int k = 1; k <= n; k++) pulse();
    csN = 1'b1;
    @(negedge clk);
    check5($sformatf("R9 abort after edge %0d", n), 5'b00011);
    // R8: clocks with cs high do nothing
    for (int k = 0; k < 8; k++) pulse();
    check5("R8 idle clocks with cs high", 5'b00011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check5("R1 reset state", 5'b00011);

    runWord(16'h0000);
    runWord(16'h8000);
    runWord(16'hFFFF);
    runWord(16'hA5C3);
    runWord(16'h0001);

    abortAt(3, 16'h1234);
    abortAt(10, 16'hFFFF);
    abortAt(25, 16'hFFFF);
    runWord(16'h7FFE);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    finished = 1;
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule